// File: doc/BRIEF.md
# Arbitrated Dual-Port Mailbox RAM

A shared 1024 x 8 memory with two symmetric ports, called left and right, for two agents that exchange data. Either port may read or write any word at any time. When both ports touch the same word and at least one of them writes, an arbiter picks one winner. The losing port sees its busy flag and its write is dropped. Two dedicated words near the top of the address space act as doorbells. A write to a port's doorbell word by the opposite port raises that port's interrupt flag. The port clears its own flag by reading the word.

The block is modelled as synchronous logic with one access per port per clock. Read data appears after the clock edge that samples the request. Busy is decided within the request cycle, so a port can see the conflict before its write would land. With the `SLAVE` parameter set, the internal arbiter is bypassed. In that mode the busy pins become inputs, so a second instance can follow a master's decision when two instances are ganged into a wider word.

Top module: `dpram_mailbox`

## Requirements
- R1: Each port writes `din` to `mem[addr]` at a clock edge when `ce_n`=0 and `rw`=0 (`rw`=1 means read). After a read edge, `dout` holds the word that was stored before that edge. Accesses to different words by both ports never interact.
- R2: Both ports reading the same word in the same cycle both get its value, and neither busy flag asserts.
- R3: After each edge, `dout_en` is 1 exactly when, at that edge, `ce_n`=0, `oe_n`=0 and `rw`=1. Otherwise it is 0.
- R4: A collision is both ports enabled on the same address with at least one write. An access is ongoing when its port was enabled on the same address in the previous cycle. In a collision between an ongoing access and a newly started one, the newcomer's `busy_n` goes low in that cycle and the ongoing port's `busy_n` stays high.
- R5: If both accesses of a collision start in the same cycle, the left port wins and `r_busy_n` is low. At most one busy flag is low at any time.
- R6: The losing port's write is suppressed, so the word keeps the winner's data.
- R7: Address 0x3FF is the left doorbell. A right-port write to it drives `l_int_n` low after the edge. A left-port read of it returns `l_int_n` to high after the edge.
- R8: Address 0x3FE is the right doorbell. A left-port write to it drives `r_int_n` low. A right-port read of it clears `r_int_n`.
- R9: A port with `ce_n`=1 does not write, does not drive `dout_en`, and takes no part in collisions.
- R10: With `SLAVE`=1, a low `busy_in_n` blocks that port's writes, and both `busy_n` outputs stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one access per port per cycle |
| rst_n | input | 1 | Active-low reset of flags and output registers |
| l_ce_n | input | 1 | Left enable, active low |
| l_rw | input | 1 | Left direction, 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left word address |
| l_din | input | DW | Left write data |
| l_busy_in_n | input | 1 | Left external busy, used only when SLAVE=1 |
| l_dout | output | DW | Left read data |
| l_dout_en | output | 1 | Left data drive enable, 0 means high impedance |
| l_busy_n | output | 1 | Left lost arbitration, active low |
| l_int_n | output | 1 | Left doorbell pending, active low |
| r_ce_n | input | 1 | Right enable, active low |
| r_rw | input | 1 | Right direction, 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right word address |
| r_din | input | DW | Right write data |
| r_busy_in_n | input | 1 | Right external busy, used only when SLAVE=1 |
| r_dout | output | DW | Right read data |
| r_dout_en | output | 1 | Right data drive enable |
| r_busy_n | output | 1 | Right lost arbitration, active low |
| r_int_n | output | 1 | Right doorbell pending, active low |

## Verification
The bench builds two instances, both with the full 10-bit address and 8-bit data. One is an arbitrating master and the other has `SLAVE`=1. The default widths place the doorbells at 0x3FF and 0x3FE, so both interrupt paths are reached with the real addresses. The master instance covers arbitration in both directions of the ongoing-versus-newcomer rule and in the simultaneous-start tie. The slave instance is the only one that shows external busy blocking a write while its own busy outputs stay quiet.

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter bit SLAVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce_n,
  input  logic          l_rw,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_din,
  input  logic          l_busy_in_n,
  output logic [DW-1:0] l_dout,
  output logic          l_dout_en,
  output logic          l_busy_n,
  output logic          l_int_n,
  input  logic          r_ce_n,
  input  logic          r_rw,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_din,
  input  logic          r_busy_in_n,
  output logic [DW-1:0] r_dout,
  output logic          r_dout_en,
  output logic          r_busy_n,
  output logic          r_int_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] MB_L = {AW{1'b1}};
  localparam logic [AW-1:0] MB_R = {{(AW-1){1'b1}}, 1'b0};

  logic [DW-1:0] mem [DEPTH];

  logic          l_pact, r_pact, owner_r;
  logic [AW-1:0] l_paddr, r_paddr;
  logic          l_int_q, r_int_q;

  wire l_act = !l_ce_n;
  wire r_act = !r_ce_n;
  wire l_new = l_act && (!l_pact || l_addr != l_paddr);
  wire r_new = r_act && (!r_pact || r_addr != r_paddr);
  wire clash = l_act && r_act && (l_addr == r_addr) && (!l_rw || !r_rw);

  logic win_r;
  always_comb begin
    if (l_new && !r_new)      win_r = 1'b1;
    else if (r_new && !l_new) win_r = 1'b0;
    else if (l_new && r_new)  win_r = 1'b0;
    else                      win_r = owner_r;
  end

  wire l_lose  = clash && win_r;
  wire r_lose  = clash && !win_r;
  wire l_block = SLAVE ? !l_busy_in_n : l_lose;
  wire r_block = SLAVE ? !r_busy_in_n : r_lose;
  wire l_we    = l_act && !l_rw && !l_block;
  wire r_we    = r_act && !r_rw && !r_block;

  assign l_busy_n = SLAVE ? 1'b1 : !l_lose;
  assign r_busy_n = SLAVE ? 1'b1 : !r_lose;
  assign l_int_n  = !l_int_q;
  assign r_int_n  = !r_int_q;

  always_ff @(posedge clk) begin
    if (l_we) mem[l_addr] <= l_din;
    if (r_we) mem[r_addr] <= r_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_pact    <= 1'b0;
      r_pact    <= 1'b0;
      l_paddr   <= '0;
      r_paddr   <= '0;
      owner_r   <= 1'b0;
      l_dout    <= '0;
      r_dout    <= '0;
      l_dout_en <= 1'b0;
      r_dout_en <= 1'b0;
      l_int_q   <= 1'b0;
      r_int_q   <= 1'b0;
    end else begin
      l_pact    <= l_act;
      r_pact    <= r_act;
      l_paddr   <= l_addr;
      r_paddr   <= r_addr;
      if (clash) owner_r <= win_r;
      l_dout_en <= l_act && !l_oe_n && l_rw;
      r_dout_en <= r_act && !r_oe_n && r_rw;
      if (l_act && l_rw) l_dout <= mem[l_addr];
      if (r_act && r_rw) r_dout <= mem[r_addr];
      if (r_we && r_addr == MB_L)           l_int_q <= 1'b1;
      else if (l_act && l_rw && l_addr == MB_L) l_int_q <= 1'b0;
      if (l_we && l_addr == MB_R)           r_int_q <= 1'b1;
      else if (r_act && r_rw && r_addr == MB_R) r_int_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dpram_mailbox_chk.sv
module dpram_mailbox_chk #(
  parameter int AW = 10,
  parameter bit SLAVE = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_ce_n,
  input logic          l_rw,
  input logic          l_oe_n,
  input logic [AW-1:0] l_addr,
  input logic          r_ce_n,
  input logic          r_rw,
  input logic          r_oe_n,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_n,
  input logic          r_busy_n,
  input logic          l_int_n,
  input logic          r_int_n,
  input logic          l_dout_en,
  input logic          r_dout_en
);
  localparam logic [AW-1:0] MB_L = {AW{1'b1}};
  localparam logic [AW-1:0] MB_R = {{(AW-1){1'b1}}, 1'b0};

  AST_L_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    l_dout_en |-> $past(!l_ce_n && !l_oe_n && l_rw)); // R3
  AST_R_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    r_dout_en |-> $past(!r_ce_n && !r_oe_n && r_rw)); // R3
  AST_BUSY_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!SLAVE && (!l_busy_n || !r_busy_n)) |-> (l_addr == r_addr && !l_ce_n && !r_ce_n)); // R4
  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    !SLAVE |-> (l_busy_n || r_busy_n)); // R5
  AST_L_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_int_n) |-> $past(!r_ce_n && !r_rw && r_addr == MB_L)); // R7
  AST_L_INT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_int_n) |-> $past(!l_ce_n && l_rw && l_addr == MB_L)); // R7
  AST_R_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_int_n) |-> $past(!l_ce_n && !l_rw && l_addr == MB_R)); // R8
  AST_R_INT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_int_n) |-> $past(!r_ce_n && r_rw && r_addr == MB_R)); // R8
  AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce_n || r_ce_n) |-> (l_busy_n && r_busy_n)); // R9
  AST_SLAVE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    SLAVE |-> (l_busy_n && r_busy_n)); // R10
endmodule

bind dpram_mailbox dpram_mailbox_chk #(.AW(AW), .SLAVE(SLAVE)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr),
  .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_int_n(l_int_n), .r_int_n(r_int_n),
  .l_dout_en(l_dout_en), .r_dout_en(r_dout_en)
);

// File: tb/tb_dpram_mailbox.sv
module tb_dpram_mailbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       l_ce_n = 1, l_rw = 1, l_oe_n = 0, r_ce_n = 1, r_rw = 1, r_oe_n = 0;
  logic [9:0] l_addr = '0, r_addr = '0;
  logic [7:0] l_din = '0, r_din = '0;
  logic [7:0] l_dout, r_dout;
  logic       l_dout_en, r_dout_en, l_busy_n, r_busy_n, l_int_n, r_int_n;

  logic       s_ce_n = 1, s_rw = 1, s_busy_in_n = 1;
  logic [9:0] s_addr = '0;
  logic [7:0] s_din = '0;
  logic [7:0] s_l_dout, s_r_dout;
  logic       s_l_en, s_r_en, s_l_busy_n, s_r_busy_n, s_l_int_n, s_r_int_n;

  dpram_mailbox #(.AW(10), .DW(8), .SLAVE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_din(l_din),
    .l_busy_in_n(1'b1), .l_dout(l_dout), .l_dout_en(l_dout_en), .l_busy_n(l_busy_n), .l_int_n(l_int_n),
    .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_din(r_din),
    .r_busy_in_n(1'b1), .r_dout(r_dout), .r_dout_en(r_dout_en), .r_busy_n(r_busy_n), .r_int_n(r_int_n));

  dpram_mailbox #(.AW(10), .DW(8), .SLAVE(1'b1)) dut_s (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(1'b1), .l_rw(1'b1), .l_oe_n(1'b0), .l_addr(10'h000), .l_din(8'h00),
    .l_busy_in_n(1'b1), .l_dout(s_l_dout), .l_dout_en(s_l_en), .l_busy_n(s_l_busy_n), .l_int_n(s_l_int_n),
    .r_ce_n(s_ce_n), .r_rw(s_rw), .r_oe_n(1'b0), .r_addr(s_addr), .r_din(s_din),
    .r_busy_in_n(s_busy_in_n), .r_dout(s_r_dout), .r_dout_en(s_r_en), .r_busy_n(s_r_busy_n), .r_int_n(s_r_int_n));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic le, input logic lw, input logic [9:0] la, input logic [7:0] ld,
                       input logic re, input logic rw, input logic [9:0] ra, input logic [7:0] rd);
    @(negedge clk);
    l_ce_n = !le; l_rw = !lw; l_addr = la; l_din = ld;
    r_ce_n = !re; r_rw = !rw; r_addr = ra; r_din = rd;
    #1;
  endtask

  task automatic edge_wait();
    @(posedge clk); #1;
  endtask

  typedef struct packed {
    logic len; logic lwr; logic [9:0] la; logic [7:0] ld;
    logic ren; logic rwr; logic [9:0] ra; logic [7:0] rd;
    logic lchk; logic [7:0] lq; logic rchk; logic [7:0] rq;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{1'b1, 1'b1, 10'h010, 8'hA5, 1'b1, 1'b1, 10'h020, 8'h3C, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b1, 1'b0, 10'h020, 8'h00, 1'b1, 1'b0, 10'h010, 8'h00, 1'b1, 8'h3C, 1'b1, 8'hA5},
    '{1'b1, 1'b0, 10'h010, 8'h00, 1'b1, 1'b0, 10'h010, 8'h00, 1'b1, 8'hA5, 1'b1, 8'hA5},
    '{1'b1, 1'b1, 10'h100, 8'h11, 1'b0, 1'b0, 10'h000, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b1, 1'b0, 10'h100, 8'h00, 1'b1, 1'b1, 10'h200, 8'h22, 1'b1, 8'h11, 1'b0, 8'h00},
    '{1'b0, 1'b0, 10'h000, 8'h00, 1'b1, 1'b0, 10'h200, 8'h00, 1'b0, 8'h00, 1'b1, 8'h22}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("reset l_busy_n", l_busy_n, 1); chk("reset r_busy_n", r_busy_n, 1);
    chk("reset l_int_n", l_int_n, 1);   chk("reset r_int_n", r_int_n, 1);
    chk("reset l_dout_en", l_dout_en, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2: table of independent and shared accesses
    foreach (TBL[i]) begin
      apply(TBL[i].len, TBL[i].lwr, TBL[i].la, TBL[i].ld, TBL[i].ren, TBL[i].rwr, TBL[i].ra, TBL[i].rd);
      chk("R2 no busy left", l_busy_n, 1);
      chk("R2 no busy right", r_busy_n, 1);
      edge_wait();
      if (TBL[i].lchk) chk("R1 left read", l_dout, TBL[i].lq);
      if (TBL[i].rchk) chk("R1 right read", r_dout, TBL[i].rq);
    end

    // R3 output drive gating
    @(negedge clk); l_oe_n = 1'b1;
    apply(1, 0, 10'h010, 0, 0, 0, 0, 0); edge_wait();
    chk("R3 oe_n high", l_dout_en, 0);
    @(negedge clk); l_oe_n = 1'b0;
    apply(1, 0, 10'h010, 0, 0, 0, 0, 0); edge_wait();
    chk("R3 read drives", l_dout_en, 1);
    chk("R1 read value", l_dout, 8'hA5);
    apply(1, 1, 10'h010, 8'hA5, 0, 0, 0, 0); edge_wait();
    chk("R3 write no drive", l_dout_en, 0);

    // R4 R6: left ongoing, right newcomer writes
    apply(0, 0, 0, 0, 0, 0, 0, 0); edge_wait();
    apply(1, 1, 10'h060, 8'h44, 0, 0, 0, 0); edge_wait();
    apply(1, 0, 10'h060, 0, 0, 0, 0, 0); edge_wait();
    apply(1, 0, 10'h060, 0, 1, 1, 10'h060, 8'h99);
    chk("R4 newcomer right busy", r_busy_n, 0);
    chk("R4 ongoing left free", l_busy_n, 1);
    edge_wait();
    apply(0, 0, 0, 0, 0, 0, 0, 0); edge_wait();
    apply(0, 0, 0, 0, 1, 0, 10'h060, 0); edge_wait();
    chk("R6 loser write dropped", r_dout, 8'h44);

    // R4 mirror: right ongoing write, left newcomer
    apply(0, 0, 0, 0, 1, 1, 10'h080, 8'h5E); edge_wait();
    apply(1, 0, 10'h080, 0, 1, 1, 10'h080, 8'h5E);
    chk("R4 newcomer left busy", l_busy_n, 0);
    chk("R4 ongoing right free", r_busy_n, 1);
    edge_wait();

    // R5 simultaneous start tie
    apply(0, 0, 0, 0, 0, 0, 0, 0); edge_wait();
    apply(1, 1, 10'h070, 8'hAA, 1, 1, 10'h070, 8'hBB);
    chk("R5 right loses tie", r_busy_n, 0);
    chk("R5 left wins tie", l_busy_n, 1);
    edge_wait();
    apply(0, 0, 0, 0, 0, 0, 0, 0); edge_wait();
    apply(1, 0, 10'h070, 0, 0, 0, 0, 0); edge_wait();
    chk("R5 R6 winner data kept", l_dout, 8'hAA);

    // R7 left doorbell
    apply(0, 0, 0, 0, 1, 1, 10'h3FF, 8'h01); edge_wait();
    chk("R7 left int set", l_int_n, 0);
    chk("R7 right int untouched", r_int_n, 1);
    apply(0, 0, 0, 0, 0, 0, 0, 0); edge_wait();
    chk("R7 left int holds", l_int_n, 0);
    apply(1, 0, 10'h3FF, 0, 0, 0, 0, 0); edge_wait();
    chk("R7 left int cleared", l_int_n, 1);
    chk("R7 mailbox data", l_dout, 8'h01);

    // R8 right doorbell
    apply(1, 1, 10'h3FE, 8'h02, 0, 0, 0, 0); edge_wait();
    chk("R8 right int set", r_int_n, 0);
    chk("R8 left int untouched", l_int_n, 1);
    apply(0, 0, 0, 0, 1, 0, 10'h3FE, 0); edge_wait();
    chk("R8 right int cleared", r_int_n, 1);
    chk("R8 mailbox data", r_dout, 8'h02);

    // R9 disabled port is inert
    apply(0, 1, 10'h010, 8'hFF, 1, 0, 10'h010, 0);
    chk("R9 no busy when disabled", r_busy_n, 1);
    edge_wait();
    chk("R9 no drive when disabled", l_dout_en, 0);
    apply(1, 0, 10'h010, 0, 0, 0, 0, 0); edge_wait();
    chk("R9 disabled write ignored", l_dout, 8'hA5);

    // R10 slave follows external busy
    @(negedge clk); s_ce_n = 0; s_rw = 0; s_addr = 10'h030; s_din = 8'h12; s_busy_in_n = 1;
    edge_wait();
    @(negedge clk); s_din = 8'h5A; s_busy_in_n = 0; #1;
    chk("R10 slave busy out right", s_r_busy_n, 1);
    chk("R10 slave busy out left", s_l_busy_n, 1);
    edge_wait();
    @(negedge clk); s_rw = 1; s_busy_in_n = 1;
    edge_wait();
    chk("R10 blocked slave write", s_r_dout, 8'h12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule